// File: doc/BRIEF.md
# Serial Control Read Port

This block is the device side of a serial control port that returns queued output bytes to a host. The bytes come from a show-ahead byte FIFO. An active-low interrupt-request line tells the host that bytes are waiting. The host lowers chip select and clocks the data out in SPI mode 0: the clock idles low, the port drives a new bit after each falling edge, and the host samples on each rising edge. Bytes go out most significant bit first.

The port itself decides where a read ends. Inside every byte, at the rising edge that samples the second-to-last bit, it checks the FIFO. If the FIFO is empty, the interrupt line goes high. The host then clocks out the final bit and raises chip select. If the FIFO still holds data, the line stays low and the next byte follows directly. If the host raises chip select before the end has been flagged, the transfer counts as aborted and every byte still queued is thrown away.

The chip select and serial clock inputs are brought into the system clock domain through a short synchronizer. The serial clock must therefore run well below the system clock.

Top module: `serial_ctl_read_port`

## Requirements
- R1: After reset, irq_n is 1, sdo_oe is 0 and fifo_pop is 0.
- R2: While chip select is high and no discard is in progress, irq_n is 0 when fifo_empty is 0 and 1 when fifo_empty is 1. It follows the FIFO within two system clocks.
- R3: sdo_oe is 0 (sdo high-impedance) while chip select is high and 1 while chip select is low.
- R4: Each byte is sent most significant bit first. The first bit is valid on sdo before the first rising serial clock edge after chip select falls. sdo changes only after a falling serial clock edge and holds while the serial clock is high.
- R5: Bytes arrive in FIFO order, several per transaction if queued. Each byte is taken with exactly one fifo_pop, and fifo_pop never fires while fifo_empty is 1.
- R6: Once chip select is low in a transaction started with irq_n low, irq_n stays low through every rising edge before the one that samples bit index BYTE_W-2 of the final byte. Bit index 0 is the most significant bit, so this edge is the 7th of 8.
- R7: At the rising edge for bit index BYTE_W-2, if the FIFO is empty, irq_n goes high. It stays high through the final rising edge and until chip select rises, even if a byte is queued after that edge.
- R8: At the rising edge for bit index BYTE_W-2, if the FIFO is not empty, irq_n stays low and the next byte is loaded at the falling edge that follows the byte's last bit.
- R9: If chip select rises before the end was flagged, all bytes still queued are popped and discarded, and irq_n is held high during the discard.
- R10: Chip select high clears the bit position. The next transaction starts with the most significant bit of a freshly loaded byte.
- R11: Bytes queued after the end was flagged are kept when chip select rises. irq_n then goes low for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select from the host, active low |
| sclk | input | 1 | Serial clock from the host |
| fifo_data | input | BYTE_W | Head byte of the output FIFO (show-ahead) |
| fifo_empty | input | 1 | Output FIFO holds no byte |
| fifo_pop | output | 1 | Consume the FIFO head byte this clock |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high-impedance |
| irq_n | output | 1 | Interrupt request, active low: data waiting / not last byte |

## Verification
The ports expose a wrong internal state within one byte time. If the bit counter is off by one, irq_n rises at the wrong rising edge, and every byte after it comes out rotated. If the end-of-transfer flag is stale, either a queued byte is lost or a byte is repeated in the next read. If the abort path is broken, a stale byte shows up as the first byte of the next transaction. If the FIFO is checked at the wrong moment, irq_n is wrong at the second-to-last bit. The scoreboard compares every received byte and every sampled irq_n bit against counts kept by the bench.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  // Advance a bit position, wrapping at the byte width.
  function automatic int unsigned bit_step(int unsigned idx, int unsigned width);
    return (idx + 1 >= width) ? 0 : idx + 1;
  endfunction

  // The rising edge where the end-of-transfer decision is taken.
  function automatic bit is_penult(int unsigned idx, int unsigned width);
    return idx == width - 2;
  endfunction

  // The rising edge that samples the final bit of a byte.
  function automatic bit is_final(int unsigned idx, int unsigned width);
    return idx == width - 1;
  endfunction

endpackage

// File: rtl/rsp_edge_sync.sv
module rsp_edge_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{INIT}};
      prev_q  <= INIT;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level = chain_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/rsp_shifter.sv
module rsp_shifter
  import rsp_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              more,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              sdo_bit,
  output logic              penult_edge,
  output logic              load_pop
);
  localparam int unsigned IW = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;

  logic [BYTE_W-1:0] sreg_q;
  logic [IW-1:0]     idx_q;
  logic              byte_done_q;
  logic              active;
  logic              refill;

  assign active      = ~cs_lvl;
  assign penult_edge = active & sclk_rise & is_penult(32'(idx_q), BYTE_W);
  assign refill      = active & sclk_fall & byte_done_q & more & ~fifo_empty;
  assign load_pop    = (active & cs_fall & ~fifo_empty) | refill;
  assign sdo_bit     = sreg_q[BYTE_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q      <= '0;
      idx_q       <= '0;
      byte_done_q <= 1'b0;
    end else if (!active) begin
      idx_q       <= '0;
      byte_done_q <= 1'b0;
    end else if (cs_fall) begin
      sreg_q      <= fifo_empty ? '0 : fifo_data;
      idx_q       <= '0;
      byte_done_q <= 1'b0;
    end else if (sclk_rise) begin
      idx_q       <= IW'(bit_step(32'(idx_q), BYTE_W));
      byte_done_q <= is_final(32'(idx_q), BYTE_W);
    end else if (sclk_fall) begin
      byte_done_q <= 1'b0;
      if (byte_done_q) sreg_q <= refill ? fifo_data : '0;
      else             sreg_q <= {sreg_q[BYTE_W-2:0], 1'b0};
    end
  end

  // R10: chip select high returns the bit position to the first bit
  p_idx_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_lvl |=> (idx_q == '0));

  // R4: data moves only on a falling clock edge or a new chip select
  p_sdo_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_lvl && !cs_fall && !sclk_fall) |=> $stable(sdo_bit));
endmodule

// File: rtl/rsp_irq_ctl.sv
module rsp_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_lvl,
  input  logic cs_rise,
  input  logic penult_edge,
  input  logic fifo_empty,
  output logic irq_n,
  output logic more,
  output logic draining,
  output logic drain_pop
);
  logic irq_q;
  logic ended_q;
  logic drain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= 1'b1;
      ended_q <= 1'b0;
      drain_q <= 1'b0;
    end else if (cs_rise) begin
      drain_q <= ~ended_q;
      ended_q <= 1'b0;
      irq_q   <= 1'b1;
    end else if (drain_q) begin
      irq_q <= 1'b1;
      if (fifo_empty) drain_q <= 1'b0;
    end else if (cs_lvl) begin
      irq_q <= fifo_empty;
    end else if (penult_edge) begin
      irq_q   <= fifo_empty;
      ended_q <= fifo_empty;
    end
  end

  assign irq_n     = irq_q;
  assign more      = ~ended_q;
  assign draining  = drain_q;
  assign drain_pop = drain_q & ~fifo_empty;

  // R6: inside a transaction the line moves only at the decision edge
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_lvl && !drain_q && !penult_edge) |=> (irq_n == $past(irq_n)));

  // R7: empty FIFO at the decision edge raises the line
  p_irq_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (penult_edge && fifo_empty && !drain_q && !cs_lvl) |=> irq_n);

  // R7: once the end is flagged the line stays high until chip select rises
  p_irq_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ended_q && !cs_lvl) |-> irq_n);

  // R9: no request is raised while discarding
  p_drain_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q |-> irq_n);
endmodule

// File: rtl/serial_ctl_read_port.sv
module serial_ctl_read_port #(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic [BYTE_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              irq_n
);
  logic cs_lvl, cs_rise, cs_fall;
  logic sclk_lvl, sclk_rise, sclk_fall;
  logic penult_edge, load_pop, drain_pop, more, draining;

  rsp_edge_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d(cs_n),
    .level(cs_lvl), .rise(cs_rise), .fall(cs_fall));

  rsp_edge_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .d(sclk),
    .level(sclk_lvl), .rise(sclk_rise), .fall(sclk_fall));

  rsp_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .more(more),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .sdo_bit(sdo), .penult_edge(penult_edge), .load_pop(load_pop));

  rsp_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_rise(cs_rise),
    .penult_edge(penult_edge), .fifo_empty(fifo_empty),
    .irq_n(irq_n), .more(more), .draining(draining), .drain_pop(drain_pop));

  assign fifo_pop = load_pop | drain_pop;
  assign sdo_oe   = ~cs_lvl;

  // R5: never consume from an empty FIFO
  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  // R9: loading and discarding never compete for the same head byte
  p_pop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_pop && drain_pop));

  // R4: data is steady while the serial clock is high
  p_sdo_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_lvl && sclk_lvl) |-> $stable(sdo));

  // R2: idle with chip select high, nothing is popped outside a discard
  p_idle_nopop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_lvl && !draining) |-> !fifo_pop);
endmodule

// File: tb/serial_ctl_read_port_test.sv
`timescale 1ns/1ps
module serial_ctl_read_port_test;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic [7:0] fifo_data;
  logic       fifo_empty;
  logic       fifo_pop, sdo, sdo_oe, irq_n;

  logic [7:0] fmem [16];
  logic [3:0] wp = '0;
  logic [3:0] rp = '0;
  logic [7:0] exp_q [$];

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign fifo_empty = (wp == rp);
  assign fifo_data  = fmem[rp];

  always @(posedge clk) if (fifo_pop && wp != rp) rp <= rp + 4'd1;

  serial_ctl_read_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .fifo_data(fifo_data), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .sdo(sdo), .sdo_oe(sdo_oe), .irq_n(irq_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] d);
    @(negedge clk);
    fmem[wp] = d;
    wp = wp + 4'd1;
    exp_q.push_back(d);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side of the host: clocks bytes and hands each to the scoreboard.
  task automatic host_read(input int abort_bits, input bit do_late, input logic [7:0] late_byte);
    int bits = 0;
    bit done = 1'b0;
    bit aborted = 1'b0;
    logic [7:0] rx;
    logic mid;
    @(negedge clk) cs_n = 1'b0;
    wait_clk(HALF);
    check(sdo_oe == 1'b1, "R3 oe with cs low", sdo_oe, 1);
    while (!done && !aborted) begin
      rx = '0;
      for (int b = 0; b < 8; b++) begin
        rx = {rx[6:0], sdo};
        sclk = 1'b1;
        wait_clk(HALF);
        bits++;
        if (b < 6) begin
          check(irq_n == 1'b0, "R6 irq low before decision edge", irq_n, 0);
        end else if (b == 6) begin
          check(irq_n == (exp_q.size() == 1), "R7/R8 irq at decision edge",
                irq_n, int'(exp_q.size() == 1));
          done = irq_n;
          if (do_late && done) begin
            @(negedge clk);
            fmem[wp] = late_byte;
            wp = wp + 4'd1;
          end
        end else if (done) begin
          check(irq_n == 1'b1, "R7 irq high through last edge", irq_n, 1);
        end
        sclk = 1'b0;
        wait_clk(HALF / 2);
        mid = sdo;
        wait_clk(HALF - HALF / 2);
        check(sdo == mid, "R4 sdo steady in low phase", sdo, mid);
        if (abort_bits > 0 && bits == abort_bits) begin
          aborted = 1'b1;
          break;
        end
      end
      if (!aborted) begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(rx == e, "R5 byte order and value", rx, e);
      end
    end
    if (aborted) exp_q.delete();
    if (do_late) exp_q.push_back(late_byte);
    @(negedge clk) cs_n = 1'b1;
    wait_clk(4 * HALF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    check(irq_n == 1'b1, "R1 irq after reset", irq_n, 1);
    check(sdo_oe == 1'b0, "R1 oe after reset", sdo_oe, 0);
    check(fifo_pop == 1'b0, "R1 pop after reset", fifo_pop, 0);
    @(negedge clk) rst_n = 1'b1;
    wait_clk(4);
    check(irq_n == 1'b1, "R2 idle empty", irq_n, 1);

    // single byte read
    push_byte(8'hA5);
    wait_clk(3);
    check(irq_n == 1'b0, "R2 idle data waiting", irq_n, 0);
    check(sdo_oe == 1'b0, "R3 oe with cs high", sdo_oe, 0);
    host_read(0, 1'b0, 8'h00);
    check(irq_n == 1'b1, "R2 idle after drain", irq_n, 1);

    // multi-byte read, order and continuation
    push_byte(8'h3C);
    push_byte(8'h81);
    push_byte(8'hFF);
    wait_clk(3);
    host_read(0, 1'b0, 8'h00);
    check(exp_q.size() == 0, "R5 all bytes delivered", exp_q.size(), 0);

    // early abort discards the rest
    push_byte(8'h11);
    push_byte(8'h22);
    push_byte(8'h33);
    push_byte(8'h44);
    wait_clk(3);
    host_read(12, 1'b0, 8'h00);
    check(wp == rp, "R9 queued bytes discarded", int'(wp - rp), 0);
    check(irq_n == 1'b1, "R9 irq high after discard", irq_n, 1);
    push_byte(8'h5A);
    wait_clk(3);
    check(irq_n == 1'b0, "R2 irq for new byte", irq_n, 0);
    host_read(0, 1'b0, 8'h00);   // R10: fresh byte from its MSB

    // byte queued after end flag is kept
    push_byte(8'h96);
    wait_clk(3);
    host_read(0, 1'b1, 8'hC3);
    check(irq_n == 1'b0, "R11 late byte kept", irq_n, 0);
    check(wp != rp, "R11 late byte not popped", int'(wp - rp), 1);
    host_read(0, 1'b0, 8'h00);
    check(irq_n == 1'b1, "R2 idle empty at end", irq_n, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule